// File: doc/BRIEF.md
# Reliability Error Interrupt Router

This block gathers single-cycle error pulses from a set of reliability sources, such as memory, PCIe and hart-local checkers. It latches each accepted error in a sticky pending bit and turns the pending set into three request lines. The firmware-first line goes to a machine-mode handler. The OS-first line goes to supervisor software. The third line requests entry into the trusted execution environment. A PCIe error or AER input is treated like any other source, so its own route bit can turn it into a firmware-first event before supervisor software sees it.

Machine-mode software programs the block through a small write port. Per source it sets the route (firmware-first or OS-first), an interrupt mask, a logging enable, an expose flag and a trusted-request enable. It also clears pending bits. A write made while the hart is below machine mode has no effect. After a firmware handler has consumed an error, it can set the expose flag for that source. The error is then handed to supervisor software, but the OS-first line rises only once the hart leaves machine mode.

Top module: `ras_irq_router`

## Requirements
- R1: After reset, every output is low, all pending bits are clear, every source is OS-first, unmasked, logging enabled, not exposed and not routed to the trusted request. A pulse on `err_evt[i]` sets `pend_o[i]` at the next clock edge when source i is unmasked and logging is enabled for it.
- R2: When logging is disabled for a source (select code 2, bit value 0), or the source is masked, a pulse leaves its pending bit clear and raises no request.
- R3: A pending, unmasked source whose route bit is 1 (select code 0) drives `fw_irq` high. One whose route bit is 0 drives `os_irq` high. Both outputs are combinational functions of registered state.
- R4: Setting the mask bit of a source that is already pending (select code 1, bit value 1) removes its contribution to `fw_irq` and `os_irq` but keeps it pending. Clearing the mask brings the request back.
- R5: A machine-mode write with select code 5 clears every pending bit whose write-data bit is 1 and leaves the other bits alone.
- R6: When an accepted error pulse and a clear of the same pending bit fall in one cycle, the bit ends up set.
- R7: A write with `priv` not equal to 3 (machine mode = 3) changes no configuration and clears no pending bit. Select codes 6 and 7 are ignored.
- R8: A pending firmware-first source whose expose bit is set (select code 3) becomes released at the clock edge that ends the first cycle in which `priv` is below 3 after a cycle at 3. From then on it drives `os_irq`. While the hart stays in machine mode, the expose bit alone raises nothing.
- R9: A released source keeps driving `os_irq` across later privilege changes until its pending bit is cleared. A release needs a new machine-mode exit to happen again.
- R10: `tee_req` is high whenever a pending source has its trusted-request bit set (select code 4), whatever its mask, route and the current privilege. While `tee_req` is high, `fw_irq` and `os_irq` are held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_evt | input | N_SRC | One-cycle error pulses, one bit per source |
| priv | input | 2 | Current hart privilege, 3 = machine mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 route, 1 mask, 2 log enable, 3 expose, 4 trusted request, 5 clear pending |
| cfg_wdata | input | N_SRC | Write data, one bit per source |
| pend_o | output | N_SRC | Sticky pending bits |
| fw_irq | output | 1 | Firmware-first interrupt request |
| os_irq | output | 1 | OS-first interrupt request |
| tee_req | output | 1 | Trusted-environment entry request |

## Verification
The hardest state to reach is the deferred release. It needs a pending firmware-first source whose expose flag was set while the hart was in machine mode, then a drop in privilege, and then the question of whether the release persists through a return to machine mode and a partial clear. Directed sequences hold the hart in machine mode for several cycles before lowering `priv`. They also set expose flags while already below machine mode, so that no exit happens. A long pseudo-random phase then mixes privilege changes, writes of every select code and error pulses. Exhaustive sweeps over route and mask, and over logging enable and event pattern, cover the four-source configuration.

// File: rtl/ras_pkg.sv
package ras_pkg;
  localparam int unsigned SEL_W = 3;
  localparam logic [1:0] PRIV_M = 2'b11;

  typedef enum logic [SEL_W-1:0] {
    SEL_ROUTE  = 3'd0,
    SEL_MASK   = 3'd1,
    SEL_LOGEN  = 3'd2,
    SEL_EXPOSE = 3'd3,
    SEL_TEE    = 3'd4,
    SEL_CLEAR  = 3'd5
  } cfg_sel_e;

  // sticky bit update: a new error beats a simultaneous clear
  function automatic logic pend_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // release flag: captured on machine exit, dropped with the pending bit
  function automatic logic rel_next(input logic cur, input logic fire, input logic pend_nx);
    return (cur | fire) & pend_nx;
  endfunction
endpackage

// File: rtl/ras_cfg_regs.sv
module ras_cfg_regs #(
  parameter int unsigned N_SRC = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_ok,
  input  logic [ras_pkg::SEL_W-1:0] sel,
  input  logic [N_SRC-1:0]         wdata,
  output logic [N_SRC-1:0]         route_q,
  output logic [N_SRC-1:0]         mask_q,
  output logic [N_SRC-1:0]         logen_q,
  output logic [N_SRC-1:0]         expose_q,
  output logic [N_SRC-1:0]         tee_q,
  output logic [N_SRC-1:0]         clr_vec
);
  import ras_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_q  <= '0;
      mask_q   <= '0;
      logen_q  <= '1;
      expose_q <= '0;
      tee_q    <= '0;
    end else if (wr_ok) begin
      case (sel)
        SEL_ROUTE:  route_q  <= wdata;
        SEL_MASK:   mask_q   <= wdata;
        SEL_LOGEN:  logen_q  <= wdata;
        SEL_EXPOSE: expose_q <= wdata;
        SEL_TEE:    tee_q    <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    clr_vec = '0;
    if (wr_ok && (sel == SEL_CLEAR)) clr_vec = wdata;
  end
endmodule

// File: rtl/ras_src_slice.sv
module ras_src_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic route,
  input  logic mask,
  input  logic logen,
  input  logic expose,
  input  logic clr,
  input  logic m_exit,
  output logic pend,
  output logic rel
);
  import ras_pkg::*;

  logic set_ev;
  logic fire;
  logic pend_nx;

  assign set_ev  = evt & ~mask & logen;
  assign fire    = m_exit & expose & pend & route;
  assign pend_nx = pend_next(pend, set_ev, clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      rel  <= 1'b0;
    end else begin
      pend <= pend_nx;
      rel  <= rel_next(rel, fire, pend_nx);
    end
  end
endmodule

// File: rtl/ras_irq_merge.sv
module ras_irq_merge #(
  parameter int unsigned N_SRC = 8
) (
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] rel,
  input  logic [N_SRC-1:0] route,
  input  logic [N_SRC-1:0] mask,
  input  logic [N_SRC-1:0] tee,
  output logic             fw_irq,
  output logic             os_irq,
  output logic             tee_req
);
  logic [N_SRC-1:0] fw_hit;
  logic [N_SRC-1:0] os_hit;
  logic [N_SRC-1:0] tee_hit;

  assign fw_hit  = pend & ~mask & route;
  assign os_hit  = pend & ~mask & (~route | rel);
  assign tee_hit = pend & tee;

  assign tee_req = |tee_hit;
  assign fw_irq  = (|fw_hit) & ~tee_req;
  assign os_irq  = (|os_hit) & ~tee_req;
endmodule

// File: rtl/ras_irq_router.sv
module ras_irq_router #(
  parameter int unsigned N_SRC = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_SRC-1:0]          err_evt,
  input  logic [1:0]                priv,
  input  logic                      cfg_we,
  input  logic [ras_pkg::SEL_W-1:0] cfg_sel,
  input  logic [N_SRC-1:0]          cfg_wdata,
  output logic [N_SRC-1:0]          pend_o,
  output logic                      fw_irq,
  output logic                      os_irq,
  output logic                      tee_req
);
  import ras_pkg::*;

  logic [1:0]       priv_q;
  logic             m_exit;
  logic             wr_ok;
  logic [N_SRC-1:0] route_q, mask_q, logen_q, expose_q, tee_q, clr_vec;
  logic [N_SRC-1:0] rel_q;

  // privilege edge: hart resets into machine mode
  always_ff @(posedge clk) begin
    if (!rst_n) priv_q <= PRIV_M;
    else        priv_q <= priv;
  end

  assign m_exit = (priv_q == PRIV_M) && (priv != PRIV_M);
  assign wr_ok  = cfg_we && (priv == PRIV_M);

  ras_cfg_regs #(.N_SRC(N_SRC)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ok    (wr_ok),
    .sel      (cfg_sel),
    .wdata    (cfg_wdata),
    .route_q  (route_q),
    .mask_q   (mask_q),
    .logen_q  (logen_q),
    .expose_q (expose_q),
    .tee_q    (tee_q),
    .clr_vec  (clr_vec)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    ras_src_slice u_slice (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (err_evt[i]),
      .route  (route_q[i]),
      .mask   (mask_q[i]),
      .logen  (logen_q[i]),
      .expose (expose_q[i]),
      .clr    (clr_vec[i]),
      .m_exit (m_exit),
      .pend   (pend_o[i]),
      .rel    (rel_q[i])
    );
  end

  ras_irq_merge #(.N_SRC(N_SRC)) u_merge (
    .pend    (pend_o),
    .rel     (rel_q),
    .route   (route_q),
    .mask    (mask_q),
    .tee     (tee_q),
    .fw_irq  (fw_irq),
    .os_irq  (os_irq),
    .tee_req (tee_req)
  );
endmodule

// File: rtl/ras_irq_router_chk.sv
module ras_irq_router_chk #(
  parameter int unsigned N_SRC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] err_evt,
  input logic [1:0]       priv,
  input logic             cfg_we,
  input logic [2:0]       cfg_sel,
  input logic [N_SRC-1:0] cfg_wdata,
  input logic [N_SRC-1:0] pend_o,
  input logic             fw_irq,
  input logic             os_irq,
  input logic             tee_req,
  input logic [N_SRC-1:0] route_q,
  input logic [N_SRC-1:0] mask_q,
  input logic [N_SRC-1:0] logen_q,
  input logic [N_SRC-1:0] expose_q,
  input logic [N_SRC-1:0] tee_q,
  input logic [N_SRC-1:0] rel_q,
  input logic             m_exit,
  input logic             wr_ok
);
  p_log_on_event_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_evt & ~mask_q & logen_q)) |=>
      ((pend_o & $past(err_evt & ~mask_q & logen_q)) == $past(err_evt & ~mask_q & logen_q)));

  p_no_stray_log_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(err_evt & ~mask_q & logen_q)) == '0));

  p_fw_needs_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fw_irq |-> (|(pend_o & route_q & ~mask_q)));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && cfg_sel == 3'd5) |=> ((pend_o & $past(cfg_wdata & ~err_evt)) == '0));

  p_low_priv_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && priv != 2'b11) |=>
      ($stable(route_q) && $stable(mask_q) && $stable(logen_q) && $stable(expose_q) && $stable(tee_q)));

  p_release_on_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rel_q & ~$past(rel_q))) |-> $past(m_exit));

  p_release_needs_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((rel_q & ~pend_o) == '0));

  p_tee_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tee_req |-> (!fw_irq && !os_irq));
endmodule

bind ras_irq_router ras_irq_router_chk #(.N_SRC(N_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .err_evt   (err_evt),
  .priv      (priv),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .cfg_wdata (cfg_wdata),
  .pend_o    (pend_o),
  .fw_irq    (fw_irq),
  .os_irq    (os_irq),
  .tee_req   (tee_req),
  .route_q   (route_q),
  .mask_q    (mask_q),
  .logen_q   (logen_q),
  .expose_q  (expose_q),
  .tee_q     (tee_q),
  .rel_q     (rel_q),
  .m_exit    (m_exit),
  .wr_ok     (wr_ok)
);

// File: tb/tb_ras_irq_router.sv
module tb_ras_irq_router;
  localparam int N = 4;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] err_evt = '0;
  logic [1:0]   priv = 2'b11;
  logic         cfg_we = 1'b0;
  logic [2:0]   cfg_sel = '0;
  logic [N-1:0] cfg_wdata = '0;
  logic [N-1:0] pend_o;
  logic         fw_irq, os_irq, tee_req;

  int nvec = 0;
  int nerr = 0;
  bit done = 0;

  logic [N-1:0] m_route, m_mask, m_logen, m_expose, m_tee, m_pend, m_rel;
  logic [1:0]   m_prev;
  logic [31:0]  lfsr = 32'hACE1_2468;

  always #(CLK_PERIOD/2) clk = ~clk;

  ras_irq_router #(.N_SRC(N)) dut (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .priv(priv),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .pend_o(pend_o), .fw_irq(fw_irq), .os_irq(os_irq), .tee_req(tee_req)
  );

  task automatic model_reset();
    m_route = '0; m_mask = '0; m_logen = '1; m_expose = '0; m_tee = '0;
    m_pend = '0; m_rel = '0; m_prev = 2'd3;
  endtask

  task automatic model_step(input logic [N-1:0] e, input logic we, input logic [2:0] sel,
                            input logic [N-1:0] wd, input logic [1:0] pv);
    bit ok, leave;
    logic [N-1:0] np, nr;
    ok    = we && (pv == 2'd3);
    leave = (m_prev == 2'd3) && (pv != 2'd3);
    for (int i = 0; i < N; i++) begin
      bit s, c, f;
      s = e[i] && !m_mask[i] && m_logen[i];
      c = ok && (sel == 3'd5) && wd[i];
      np[i] = s ? 1'b1 : (c ? 1'b0 : m_pend[i]);
      f = leave && m_expose[i] && m_pend[i] && m_route[i];
      nr[i] = np[i] ? (m_rel[i] || f) : 1'b0;
    end
    m_pend = np;
    m_rel  = nr;
    if (ok) begin
      if (sel == 3'd0) m_route  = wd;
      if (sel == 3'd1) m_mask   = wd;
      if (sel == 3'd2) m_logen  = wd;
      if (sel == 3'd3) m_expose = wd;
      if (sel == 3'd4) m_tee    = wd;
    end
    m_prev = pv;
  endtask

  task automatic compare(input string tag);
    bit et, ef, eo;
    et = 0; ef = 0; eo = 0;
    for (int i = 0; i < N; i++) begin
      if (m_pend[i] && m_tee[i]) et = 1;
      if (m_pend[i] && !m_mask[i]) begin
        if (!m_route[i] || m_rel[i]) eo = 1;
        if (m_route[i]) ef = 1;
      end
    end
    if (et) begin ef = 0; eo = 0; end
    nvec++;
    if (pend_o !== m_pend || fw_irq !== ef || os_irq !== eo || tee_req !== et) begin
      nerr++;
      $display("FAIL %s: pend=%h fw=%b os=%b tee=%b expected pend=%h fw=%b os=%b tee=%b",
               tag, pend_o, fw_irq, os_irq, tee_req, m_pend, ef, eo, et);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(input logic [N-1:0] e, input logic we, input logic [2:0] sel,
                      input logic [N-1:0] wd, input logic [1:0] pv, input string tag);
    err_evt = e; cfg_we = we; cfg_sel = sel; cfg_wdata = wd; priv = pv;
    @(posedge clk);
    model_step(e, we, sel, wd, pv);
    @(negedge clk);
    err_evt = '0; cfg_we = 1'b0;
    compare(tag);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [N-1:0] wd, input string tag);
    step('0, 1'b1, sel, wd, 2'd3, tag);
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1 reset state");

    // R1 R3 R4 R5: exhaustive route x mask
    for (int r = 0; r < 16; r++) begin
      for (int mk = 0; mk < 16; mk++) begin
        wr(3'd0, 4'(r), "R3 route write");
        wr(3'd1, 4'(mk), "R4 mask write");
        step(4'hF, 1'b0, 3'd0, '0, 2'd3, "R1 event latch");
        wr(3'd1, 4'h0, "R4 unmask pending");
        wr(3'd5, 4'(mk ^ 4'h5), "R5 partial clear");
        wr(3'd5, 4'hF, "R5 full clear");
      end
    end
    wr(3'd0, 4'h0, "R3 route restore");

    // R2: logging enable x event pattern
    for (int lg = 0; lg < 16; lg++) begin
      for (int ev = 1; ev < 16; ev++) begin
        wr(3'd2, 4'(lg), "R2 log enable write");
        step(4'(ev), 1'b0, 3'd0, '0, 2'd3, "R2 event gated by log");
        wr(3'd5, 4'hF, "R2 clear");
      end
    end
    wr(3'd2, 4'hF, "R2 log restore");

    // R7: writes below machine mode
    for (int pv = 0; pv < 3; pv++) begin
      step('0, 1'b1, 3'd1, 4'hF, 2'(pv), "R7 mask write ignored");
      step('0, 1'b1, 3'd2, 4'h0, 2'(pv), "R7 log write ignored");
      step(4'h6, 1'b0, 3'd0, '0, 2'(pv), "R7 event still routed");
      step('0, 1'b1, 3'd5, 4'hF, 2'(pv), "R7 clear ignored");
      step('0, 1'b0, 3'd0, '0, 2'd3, "R7 return to machine");
      wr(3'd6, 4'hF, "R7 unused select");
      wr(3'd5, 4'hF, "R7 clear");
    end

    // R6: event and clear in one cycle
    step(4'h3, 1'b0, 3'd0, '0, 2'd3, "R6 setup");
    step(4'h2, 1'b1, 3'd5, 4'hF, 2'd3, "R6 event beats clear");
    wr(3'd5, 4'hF, "R6 clear");

    // R8 R9: deferred release
    wr(3'd0, 4'hF, "R8 firmware-first");
    step(4'hF, 1'b0, 3'd0, '0, 2'd3, "R8 events pending");
    wr(3'd3, 4'h5, "R8 expose in machine");
    for (int k = 0; k < 5; k++) step('0, 1'b0, 3'd0, '0, 2'd3, "R8 held in machine");
    step('0, 1'b0, 3'd0, '0, 2'd1, "R8 release on exit");
    step('0, 1'b0, 3'd0, '0, 2'd0, "R8 no second exit");
    for (int k = 0; k < 3; k++) step('0, 1'b0, 3'd0, '0, 2'd3, "R9 release persists");
    wr(3'd5, 4'h1, "R9 one released cleared");
    wr(3'd5, 4'h4, "R9 last released cleared");
    step(4'h4, 1'b0, 3'd0, '0, 2'd3, "R9 new event not released");
    step('0, 1'b0, 3'd0, '0, 2'd1, "R9 new exit releases again");
    step('0, 1'b0, 3'd0, '0, 2'd3, "R9 back to machine");
    wr(3'd3, 4'h0, "R8 expose off");
    wr(3'd5, 4'hF, "R8 clear");
    step('0, 1'b0, 3'd0, '0, 2'd1, "R8 lower privilege");
    step(4'h8, 1'b0, 3'd0, '0, 2'd1, "R8 event in supervisor");
    step('0, 1'b1, 3'd3, 4'h8, 2'd1, "R8 expose ignored below machine");
    step('0, 1'b0, 3'd0, '0, 2'd3, "R8 enter machine");
    wr(3'd3, 4'h8, "R8 expose while in machine");
    step('0, 1'b0, 3'd0, '0, 2'd2, "R8 exit releases");

    // R10: trusted request priority
    wr(3'd5, 4'hF, "R10 clear");
    wr(3'd4, 4'h8, "R10 tee enable");
    step(4'h7, 1'b0, 3'd0, '0, 2'd3, "R10 others pending");
    wr(3'd1, 4'hF, "R10 mask all");
    wr(3'd1, 4'h0, "R10 unmask");
    step(4'h8, 1'b0, 3'd0, '0, 2'd3, "R10 tee in machine");
    wr(3'd1, 4'h8, "R10 mask tee source");
    step('0, 1'b0, 3'd0, '0, 2'd1, "R10 tee below machine");
    step('0, 1'b0, 3'd0, '0, 2'd3, "R10 back in machine");
    wr(3'd5, 4'h8, "R10 tee cleared");
    wr(3'd1, 4'h0, "R10 restore mask");

    // mixed pseudo-random sequence over every input
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] e, wd;
      logic [1:0] pv;
      logic we;
      lfsr = next_rand(lfsr); lfsr = next_rand(lfsr); lfsr = next_rand(lfsr);
      e  = lfsr[3:0] & lfsr[7:4] & lfsr[11:8];
      we = lfsr[12] & lfsr[13];
      wd = lfsr[19:16];
      pv = (lfsr[20] | lfsr[21]) ? 2'd3 : lfsr[23:22];
      step(e, we, lfsr[26:24], wd, pv, "R3/R8 mixed sequence");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule